// File: doc/BRIEF.md
# Five-Slot VLIW Bundle Packer

This block takes a stream of decoded scalar instructions and packs them into five-slot VLIW bundles. Incoming instructions collect in a lookahead window that holds up to eight entries in age order. Whenever the window is not empty the block offers a bundle. The bundle is built by walking the window from oldest to youngest. Each instruction is placed if it is free of conflicts with the instructions already chosen and with the older ones passed over, and if a slot that can run its operation class is still open. Slots that nobody fills are sent out as NOPs.

The five slots differ. Slots 0 to 3 are general slots. Slot 4 is the special slot. A younger instruction may overtake an older one that is held back, as long as no register hazard links the two. The instructions chosen for a bundle leave the window when the bundle is taken, and the rest close up in age order. Both sides use valid/ready handshakes. The block has no register file, no execution units and no branch handling. Dependencies are tracked only between instructions that are still in the window.

Top module: `vlw_packer`

## Requirements
- R1: Every bundle has five slots. A slot with no instruction has its slot-valid bit at 0, its class field at 7 (NOP) and its register fields at zero.
- R2: Slots 0 to 3 receive only class 0 (FP arithmetic: multiply-add, add, multiply), class 1 (integer add) and class 4 (shift). A class 0, 1 or 4 instruction takes the lowest-numbered general slot that is still free.
- R3: Slot 4 receives only class 0, class 2 (integer multiply), class 3 (transcendental) and class 4. A class 2 or class 3 instruction can only go to slot 4. A class 0 instruction goes to slot 4 only when slots 0 to 3 are already full.
- R4: A class 4 shift can run in any slot. It takes the lowest free general slot first and uses slot 4 only when slots 0 to 3 are full.
- R5: An instruction is not placed in a bundle if one of its enabled sources names the destination of an instruction already chosen for that bundle.
- R6: A younger instruction may go into the bundle ahead of an older instruction that was passed over, as long as no hazard links the two.
- R7: An instruction is not placed if an older instruction that was passed over in the same scan creates a hazard with it. The hazards are: it writes a register that the older one reads, it writes a register that the older one writes, or it reads a register that the older one writes.
- R8: The scan runs from oldest to youngest, and the oldest instruction is always placed. When a bundle is taken, the instructions it carries leave the window. The others stay in age order and go into later bundles.
- R9: The window holds 8 instructions. `in_ready` is low while all 8 places are taken.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, no instruction leaves the window, and every slot that is filled stays filled.
- R11: Input classes 5, 6 and 7 are accepted while `in_ready` is high and then dropped. They never appear in any bundle.
- R12: While reset is asserted, and afterwards until the first instruction arrives, the window is empty: `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The window has a free place |
| in_cls | input | 3 | Operation class |
| in_dst | input | REG_W | Destination register |
| in_dst_en | input | 1 | The destination is written |
| in_src | input | NSRC*REG_W | Source registers; source s at bits [s*REG_W +: REG_W] |
| in_src_en | input | NSRC | Per-source enable |
| out_valid | output | 1 | A bundle is offered |
| out_ready | input | 1 | The consumer takes the bundle |
| out_slot_v | output | 5 | Per-slot valid flag |
| out_cls | output | 15 | Class per slot; slot k at [k*3 +: 3] |
| out_dst | output | 5*REG_W | Destination per slot |
| out_dst_en | output | 5 | Destination enable per slot |
| out_src | output | 5*NSRC*REG_W | Sources per slot; slot k at [k*NSRC*REG_W +: NSRC*REG_W] |
| out_src_en | output | 5*NSRC | Source enables per slot |

## Verification
The bench uses the default parameters: an 8-entry window, 7-bit register indices and three sources. Because the window matches the depth in the requirements, the bench can fill it completely and check that the input back-pressures. Holding the output stalled lets whole instruction groups load before any bundle is taken, so each expected bundle follows directly from the slot and hazard rules. Those groups cover every overflow into the special slot, hoisting past held-back instructions, each of the three hazard kinds, and discarded classes.

// File: rtl/vlw_pkg.sv
// Package: operation class codes and slot capability functions shared by
// the bundle packer. Assumes a fixed five-slot bundle: slots 0..3 general,
// slot 4 special.
package vlw_pkg;

    localparam int NUM_SLOTS = 5;
    localparam int GEN_SLOTS = 4;
    localparam int SPC_SLOT  = 4;
    localparam int CLS_W     = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_FPA   = 3'd0,
        CLS_IADD  = 3'd1,
        CLS_IMUL  = 3'd2,
        CLS_TRANS = 3'd3,
        CLS_SHIFT = 3'd4,
        CLS_NOP   = 3'd7
    } op_cls_e;

    // Class may run in one of the general slots.
    function automatic logic fits_gen(input logic [CLS_W-1:0] c);
        return (c == CLS_FPA) || (c == CLS_IADD) || (c == CLS_SHIFT);
    endfunction

    // Class may run in the special slot.
    function automatic logic fits_spc(input logic [CLS_W-1:0] c);
        return (c == CLS_FPA) || (c == CLS_IMUL) || (c == CLS_TRANS) || (c == CLS_SHIFT);
    endfunction

    // Class is one the packer keeps; all others are dropped on entry.
    function automatic logic is_kept(input logic [CLS_W-1:0] c);
        return fits_gen(c) || fits_spc(c);
    endfunction

endpackage

// File: rtl/vlw_window.sv
// Module: lookahead window. Holds up to DEPTH decoded instructions in age
// order (entry 0 oldest). Each cycle the entries flagged in pop_mask are
// removed, the survivors close up in order, and an optional new entry is
// appended behind them. Assumes push is only raised when a place is free.
module vlw_window #(
    parameter int DEPTH = 8,
    parameter int REG_W = 7,
    parameter int NSRC  = 3,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   push,
    input  logic [vlw_pkg::CLS_W-1:0]              push_cls,
    input  logic [REG_W-1:0]                       push_dst,
    input  logic                                   push_dst_en,
    input  logic [NSRC-1:0][REG_W-1:0]             push_src,
    input  logic [NSRC-1:0]                        push_src_en,
    input  logic [DEPTH-1:0]                       pop_mask,
    output logic [CNT_W-1:0]                       count,
    output logic [DEPTH-1:0]                       occ,
    output logic [DEPTH-1:0][vlw_pkg::CLS_W-1:0]   e_cls,
    output logic [DEPTH-1:0][REG_W-1:0]            e_dst,
    output logic [DEPTH-1:0]                       e_dst_en,
    output logic [DEPTH-1:0][NSRC-1:0][REG_W-1:0]  e_src,
    output logic [DEPTH-1:0][NSRC-1:0]             e_src_en
);

    logic [CNT_W-1:0]                       n_count;
    logic [DEPTH-1:0][vlw_pkg::CLS_W-1:0]   n_cls;
    logic [DEPTH-1:0][REG_W-1:0]            n_dst;
    logic [DEPTH-1:0]                       n_dst_en;
    logic [DEPTH-1:0][NSRC-1:0][REG_W-1:0]  n_src;
    logic [DEPTH-1:0][NSRC-1:0]             n_src_en;
    logic [CNT_W-1:0]                       wr;

    // Occupancy flags: entry g is live when it sits below the count.
    for (genvar g = 0; g < DEPTH; g++) begin : g_occ
        assign occ[g] = (CNT_W'(g) < count);
    end

    // Close up the survivors in age order, then append the new entry.
    always_comb begin
        n_cls    = '0;
        n_dst    = '0;
        n_dst_en = '0;
        n_src    = '0;
        n_src_en = '0;
        wr       = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (occ[i] && !pop_mask[i]) begin
                n_cls[wr[IDX_W-1:0]]    = e_cls[i];
                n_dst[wr[IDX_W-1:0]]    = e_dst[i];
                n_dst_en[wr[IDX_W-1:0]] = e_dst_en[i];
                n_src[wr[IDX_W-1:0]]    = e_src[i];
                n_src_en[wr[IDX_W-1:0]] = e_src_en[i];
                wr = wr + 1'b1;
            end
        end
        if (push && (wr < CNT_W'(DEPTH))) begin
            n_cls[wr[IDX_W-1:0]]    = push_cls;
            n_dst[wr[IDX_W-1:0]]    = push_dst;
            n_dst_en[wr[IDX_W-1:0]] = push_dst_en;
            n_src[wr[IDX_W-1:0]]    = push_src;
            n_src_en[wr[IDX_W-1:0]] = push_src_en;
            wr = wr + 1'b1;
        end
        n_count = wr;
    end

    // Window state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            e_cls    <= '0;
            e_dst    <= '0;
            e_dst_en <= '0;
            e_src    <= '0;
            e_src_en <= '0;
        end else begin
            count    <= n_count;
            e_cls    <= n_cls;
            e_dst    <= n_dst;
            e_dst_en <= n_dst_en;
            e_src    <= n_src;
            e_src_en <= n_src_en;
        end
    end

endmodule

// File: rtl/vlw_hazard.sv
// Module: pairwise register hazard matrices over the window. For entries
// i and j: raw_m[i][j] means i reads a register j writes, war_m[i][j]
// means i writes a register j reads, waw_m[i][j] means both write the
// same register. Only enabled fields count. Purely combinational.
module vlw_hazard #(
    parameter int DEPTH = 8,
    parameter int REG_W = 7,
    parameter int NSRC  = 3
) (
    input  logic [DEPTH-1:0][REG_W-1:0]            e_dst,
    input  logic [DEPTH-1:0]                       e_dst_en,
    input  logic [DEPTH-1:0][NSRC-1:0][REG_W-1:0]  e_src,
    input  logic [DEPTH-1:0][NSRC-1:0]             e_src_en,
    output logic [DEPTH-1:0][DEPTH-1:0]            raw_m,
    output logic [DEPTH-1:0][DEPTH-1:0]            war_m,
    output logic [DEPTH-1:0][DEPTH-1:0]            waw_m
);

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
        for (genvar gj = 0; gj < DEPTH; gj++) begin : g_col
            // Compare the sources of one entry with the destination of the other.
            always_comb begin
                raw_m[gi][gj] = 1'b0;
                war_m[gi][gj] = 1'b0;
                for (int s = 0; s < NSRC; s++) begin
                    if (e_src_en[gi][s] && e_dst_en[gj] && (e_src[gi][s] == e_dst[gj]))
                        raw_m[gi][gj] = 1'b1;
                    if (e_src_en[gj][s] && e_dst_en[gi] && (e_src[gj][s] == e_dst[gi]))
                        war_m[gi][gj] = 1'b1;
                end
            end
            assign waw_m[gi][gj] = e_dst_en[gi] && e_dst_en[gj] && (e_dst[gi] == e_dst[gj]);
        end
    end

endmodule

// File: rtl/vlw_select.sv
// Module: bundle selector. Scans the live window entries oldest first and
// places each one whose hazards allow it into the lowest free slot that
// can run its class (general slots before the special slot). Entries not
// placed are recorded as passed over, and they constrain younger ones.
// Assumes every live entry has a kept class, so entry 0 always fits.
module vlw_select #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]                       occ,
    input  logic [DEPTH-1:0][vlw_pkg::CLS_W-1:0]   e_cls,
    input  logic [DEPTH-1:0][DEPTH-1:0]            raw_m,
    input  logic [DEPTH-1:0][DEPTH-1:0]            war_m,
    input  logic [DEPTH-1:0][DEPTH-1:0]            waw_m,
    output logic [DEPTH-1:0]                       pick,
    output logic [vlw_pkg::NUM_SLOTS-1:0]          slot_v,
    output logic [vlw_pkg::NUM_SLOTS-1:0][IDX_W-1:0] slot_idx
);
    import vlw_pkg::*;

    logic [DEPTH-1:0]     passed;
    logic [GEN_SLOTS-1:0] gen_free;
    logic                 spc_free;
    logic                 blocked;
    logic                 placed;

    // Oldest-first greedy placement with hazard and capability checks.
    always_comb begin
        pick     = '0;
        passed   = '0;
        slot_v   = '0;
        slot_idx = '0;
        gen_free = '1;
        spc_free = 1'b1;
        blocked  = 1'b0;
        placed   = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            blocked = 1'b0;
            placed  = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (pick[j] && raw_m[i][j])
                    blocked = 1'b1;
                if (passed[j] && (raw_m[i][j] || war_m[i][j] || waw_m[i][j]))
                    blocked = 1'b1;
            end
            if (occ[i] && !blocked) begin
                if (fits_gen(e_cls[i])) begin
                    for (int k = 0; k < GEN_SLOTS; k++) begin
                        if (!placed && gen_free[k]) begin
                            gen_free[k] = 1'b0;
                            slot_v[k]   = 1'b1;
                            slot_idx[k] = IDX_W'(i);
                            placed      = 1'b1;
                        end
                    end
                end
                if (!placed && fits_spc(e_cls[i]) && spc_free) begin
                    spc_free           = 1'b0;
                    slot_v[SPC_SLOT]   = 1'b1;
                    slot_idx[SPC_SLOT] = IDX_W'(i);
                    placed             = 1'b1;
                end
            end
            pick[i]   = placed;
            passed[i] = occ[i] && !placed;
        end
    end

endmodule

// File: rtl/vlw_packer.sv
// Module: five-slot VLIW bundle packer top. Accepts decoded instructions
// over a valid/ready input into a lookahead window, offers one bundle per
// cycle while the window is not empty, and retires the placed entries
// when the bundle is taken. Classes outside the kept set are dropped on
// entry. Assumes a synchronous active-low reset.
module vlw_packer #(
    parameter int WIN_DEPTH = 8,
    parameter int REG_W     = 7,
    parameter int NSRC      = 3,
    localparam int NS       = vlw_pkg::NUM_SLOTS,
    localparam int CW       = vlw_pkg::CLS_W,
    localparam int CNT_W    = $clog2(WIN_DEPTH + 1),
    localparam int IDX_W    = $clog2(WIN_DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [CW-1:0]              in_cls,
    input  logic [REG_W-1:0]           in_dst,
    input  logic                       in_dst_en,
    input  logic [NSRC*REG_W-1:0]      in_src,
    input  logic [NSRC-1:0]            in_src_en,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [NS-1:0]              out_slot_v,
    output logic [NS*CW-1:0]           out_cls,
    output logic [NS*REG_W-1:0]        out_dst,
    output logic [NS-1:0]              out_dst_en,
    output logic [NS*NSRC*REG_W-1:0]   out_src,
    output logic [NS*NSRC-1:0]         out_src_en
);
    import vlw_pkg::*;

    logic [CNT_W-1:0]                          win_count;
    logic [WIN_DEPTH-1:0]                      occ;
    logic [WIN_DEPTH-1:0][CW-1:0]              e_cls;
    logic [WIN_DEPTH-1:0][REG_W-1:0]           e_dst;
    logic [WIN_DEPTH-1:0]                      e_dst_en;
    logic [WIN_DEPTH-1:0][NSRC-1:0][REG_W-1:0] e_src;
    logic [WIN_DEPTH-1:0][NSRC-1:0]            e_src_en;
    logic [WIN_DEPTH-1:0][WIN_DEPTH-1:0]       raw_m;
    logic [WIN_DEPTH-1:0][WIN_DEPTH-1:0]       war_m;
    logic [WIN_DEPTH-1:0][WIN_DEPTH-1:0]       waw_m;
    logic [WIN_DEPTH-1:0]                      pick;
    logic [NS-1:0]                             slot_v;
    logic [NS-1:0][IDX_W-1:0]                  slot_idx;
    logic                                      push;
    logic                                      fire;
    logic [WIN_DEPTH-1:0]                      pop_mask;
    logic [NSRC-1:0][REG_W-1:0]                push_src;

    // Handshake glue: room check, drop of unkept classes, retire on take.
    assign in_ready  = (win_count < CNT_W'(WIN_DEPTH));
    assign push      = in_valid && in_ready && is_kept(in_cls);
    assign out_valid = (win_count != '0);
    assign fire      = out_valid && out_ready;
    assign pop_mask  = fire ? pick : '0;
    assign push_src  = in_src;

    vlw_window #(.DEPTH(WIN_DEPTH), .REG_W(REG_W), .NSRC(NSRC)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_cls    (in_cls),
        .push_dst    (in_dst),
        .push_dst_en (in_dst_en),
        .push_src    (push_src),
        .push_src_en (in_src_en),
        .pop_mask    (pop_mask),
        .count       (win_count),
        .occ         (occ),
        .e_cls       (e_cls),
        .e_dst       (e_dst),
        .e_dst_en    (e_dst_en),
        .e_src       (e_src),
        .e_src_en    (e_src_en)
    );

    vlw_hazard #(.DEPTH(WIN_DEPTH), .REG_W(REG_W), .NSRC(NSRC)) u_hazard (
        .e_dst    (e_dst),
        .e_dst_en (e_dst_en),
        .e_src    (e_src),
        .e_src_en (e_src_en),
        .raw_m    (raw_m),
        .war_m    (war_m),
        .waw_m    (waw_m)
    );

    vlw_select #(.DEPTH(WIN_DEPTH)) u_select (
        .occ      (occ),
        .e_cls    (e_cls),
        .raw_m    (raw_m),
        .war_m    (war_m),
        .waw_m    (waw_m),
        .pick     (pick),
        .slot_v   (slot_v),
        .slot_idx (slot_idx)
    );

    assign out_slot_v = slot_v;

    for (genvar k = 0; k < NS; k++) begin : g_slot
        // Route the chosen entry into slot k, or a NOP when empty.
        always_comb begin
            if (slot_v[k]) begin
                out_cls[k*CW +: CW]                      = e_cls[slot_idx[k]];
                out_dst[k*REG_W +: REG_W]                = e_dst[slot_idx[k]];
                out_dst_en[k]                            = e_dst_en[slot_idx[k]];
                out_src[k*NSRC*REG_W +: NSRC*REG_W]      = e_src[slot_idx[k]];
                out_src_en[k*NSRC +: NSRC]               = e_src_en[slot_idx[k]];
            end else begin
                out_cls[k*CW +: CW]                      = CLS_NOP;
                out_dst[k*REG_W +: REG_W]                = '0;
                out_dst_en[k]                            = 1'b0;
                out_src[k*NSRC*REG_W +: NSRC*REG_W]      = '0;
                out_src_en[k*NSRC +: NSRC]               = '0;
            end
        end
    end

endmodule

// File: rtl/vlw_packer_chk.sv
// Module: assertion checker for the bundle packer, attached by bind.
// Observes the bundle outputs, the output handshake and the window count.
module vlw_packer_chk #(
    parameter int WIN_DEPTH = 8,
    localparam int CNT_W    = $clog2(WIN_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [4:0]       out_slot_v,
    input logic [14:0]      out_cls,
    input logic [CNT_W-1:0] win_count
);

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_count <= CNT_W'(WIN_DEPTH));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && ((out_slot_v & $past(out_slot_v)) == $past(out_slot_v))));

    // R8
    oldest_placed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slot_v != 5'd0));

    // R12
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);

    for (genvar k = 0; k < 5; k++) begin : g_nop
        // R1
        nop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_slot_v[k] |-> (out_cls[k*3 +: 3] == 3'd7));
    end

    for (genvar k = 0; k < 4; k++) begin : g_gen
        // R2
        gen_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_slot_v[k] |-> (out_cls[k*3 +: 3] == 3'd0 || out_cls[k*3 +: 3] == 3'd1 ||
                               out_cls[k*3 +: 3] == 3'd4));
    end

    // R3
    spc_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_slot_v[4] |-> (out_cls[14:12] == 3'd0 || out_cls[14:12] == 3'd2 ||
                           out_cls[14:12] == 3'd3 || out_cls[14:12] == 3'd4));

    // R3
    spc_fp_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_slot_v[4] && out_cls[14:12] == 3'd0) |-> (&out_slot_v[3:0]));

    // R4
    spc_shift_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_slot_v[4] && out_cls[14:12] == 3'd4) |-> (&out_slot_v[3:0]));

endmodule

bind vlw_packer vlw_packer_chk #(.WIN_DEPTH(WIN_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_slot_v (out_slot_v),
    .out_cls    (out_cls),
    .win_count  (win_count)
);

// File: tb/vlw_packer_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks load instruction groups and queue the
// expected bundles; a monitor compares each bundle as it is taken.
module vlw_packer_tb;

    localparam int REG_W = 7;
    localparam int NSRC  = 3;
    localparam int NOP   = -1;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic                     in_ready;
    logic [2:0]               in_cls = '0;
    logic [REG_W-1:0]         in_dst = '0;
    logic                     in_dst_en = 1'b0;
    logic [NSRC*REG_W-1:0]    in_src = '0;
    logic [NSRC-1:0]          in_src_en = '0;
    logic                     out_valid;
    logic                     out_ready = 1'b0;
    logic [4:0]               out_slot_v;
    logic [14:0]              out_cls;
    logic [5*REG_W-1:0]       out_dst;
    logic [4:0]               out_dst_en;
    logic [5*NSRC*REG_W-1:0]  out_src;
    logic [5*NSRC-1:0]        out_src_en;

    int n_cmp = 0;
    int n_bad = 0;
    logic [39:0] exp_q[$];
    string       tag_q[$];

    vlw_packer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_dst(in_dst), .in_dst_en(in_dst_en),
        .in_src(in_src), .in_src_en(in_src_en), .out_valid(out_valid),
        .out_ready(out_ready), .out_slot_v(out_slot_v), .out_cls(out_cls),
        .out_dst(out_dst), .out_dst_en(out_dst_en), .out_src(out_src),
        .out_src_en(out_src_en)
    );

    always #4 clk = ~clk;

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Slot key: 8'hFF for a proper NOP, 8'hFE for a malformed empty slot, else dst.
    function automatic logic [39:0] bundle_key();
        logic [39:0] key;
        for (int k = 0; k < 5; k++) begin
            if (out_slot_v[k])
                key[k*8 +: 8] = {1'b0, out_dst[k*REG_W +: REG_W]};
            else if (out_cls[k*3 +: 3] == 3'd7 && out_dst[k*REG_W +: REG_W] == '0)
                key[k*8 +: 8] = 8'hFF;
            else
                key[k*8 +: 8] = 8'hFE;
        end
        return key;
    endfunction

    function automatic logic [7:0] slot_code(input int d);
        return (d < 0) ? 8'hFF : {1'b0, 7'(d)};
    endfunction

    task automatic expect_b(input string req, input int s0, input int s1, input int s2, input int s3, input int s4);
        exp_q.push_back({slot_code(s4), slot_code(s3), slot_code(s2), slot_code(s1), slot_code(s0)});
        tag_q.push_back(req);
    endtask

    task automatic push(input int cls, input int dst, input logic [2:0] sen, input int a, input int b, input int c);
        @(posedge clk); #1;
        in_valid  = 1'b1;
        in_cls    = 3'(cls);
        in_dst    = 7'(dst);
        in_dst_en = 1'b1;
        in_src    = {7'(c), 7'(b), 7'(a)};
        in_src_en = sen;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid  = 1'b0;
    endtask

    task automatic drain(input string req);
        @(posedge clk); #1;
        out_ready = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
        out_ready = 1'b0;
        @(negedge clk);
        check(!out_valid, req, 64'(out_valid), 64'd0);
    endtask

    // Monitor: compare every taken bundle against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected bundle actual=%h expected=none", bundle_key());
            end else begin
                logic [39:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bundle_key() == e, t, 64'(bundle_key()), 64'(e));
            end
        end
    end

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (4) @(negedge clk);
        check(!out_valid && in_ready, "R12 in reset", {62'd0, out_valid, in_ready}, 64'd1);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && in_ready, "R12 after reset", {62'd0, out_valid, in_ready}, 64'd1);

        // R5 R6 R1: I1 writes r1, I2 reads r1, I3 independent
        push(0, 1, 3'b001, 1, 0, 0);
        push(0, 2, 3'b001, 1, 0, 0);
        push(0, 3, 3'b001, 0, 0, 0);
        expect_b("R6 hoist independent / R1 nop fill", 1, 3, NOP, NOP, NOP);
        expect_b("R5 same-bundle read deferred", 2, NOP, NOP, NOP, NOP);
        drain("R8 window empty after group 1");

        // R2 R3 R4: class mapping
        push(2, 10, 3'b000, 0, 0, 0);
        push(3, 11, 3'b000, 0, 0, 0);
        push(1, 12, 3'b000, 0, 0, 0);
        push(0, 13, 3'b000, 0, 0, 0);
        push(4, 14, 3'b000, 0, 0, 0);
        expect_b("R2 R4 general fill order, R3 multiply in special", 12, 13, 14, NOP, 10);
        expect_b("R3 transcendental waits for special", NOP, NOP, NOP, NOP, 11);
        drain("R8 window empty after group 2");

        // R3 R8: six FP ops overflow into special then next bundle
        for (int n = 0; n < 6; n++) push(0, 20 + n, 3'b000, 0, 0, 0);
        expect_b("R3 FP uses special when general full", 20, 21, 22, 23, 24);
        expect_b("R8 leftover keeps age order", 25, NOP, NOP, NOP, NOP);
        drain("R8 window empty after group 3");

        // R4: shift takes special when general full; int add cannot
        for (int n = 0; n < 4; n++) push(1, 30 + n, 3'b000, 0, 0, 0);
        push(4, 34, 3'b000, 0, 0, 0);
        push(1, 35, 3'b000, 0, 0, 0);
        expect_b("R4 shift into special", 30, 31, 32, 33, 34);
        expect_b("R2 int add never in special", 35, NOP, NOP, NOP, NOP);
        drain("R8 window empty after group 4");

        // R7 WAR: FP writes r60 read by passed-over multiply
        push(2, 40, 3'b000, 0, 0, 0);
        push(2, 41, 3'b001, 60, 0, 0);
        push(0, 60, 3'b000, 0, 0, 0);
        push(0, 42, 3'b000, 0, 0, 0);
        expect_b("R7 WAR blocks hoist, R6 free one hoisted", 42, NOP, NOP, NOP, 40);
        expect_b("R7 WAR pair together later", 60, NOP, NOP, NOP, 41);
        drain("R8 window empty after group 5");

        // R7 WAW
        push(3, 70, 3'b000, 0, 0, 0);
        push(3, 71, 3'b000, 0, 0, 0);
        push(0, 71, 3'b000, 0, 0, 0);
        expect_b("R7 WAW blocks hoist", NOP, NOP, NOP, NOP, 70);
        expect_b("R7 WAW after older placed", 71, NOP, NOP, NOP, 71);
        drain("R8 window empty after group 6");

        // R7 RAW over passed-over, then R5 against chosen
        push(3, 72, 3'b000, 0, 0, 0);
        push(3, 73, 3'b000, 0, 0, 0);
        push(0, 74, 3'b010, 0, 73, 0);
        expect_b("R7 RAW blocks hoist", NOP, NOP, NOP, NOP, 72);
        expect_b("R5 reader kept out of writer bundle", NOP, NOP, NOP, NOP, 73);
        expect_b("R5 reader issues alone", 74, NOP, NOP, NOP, NOP);
        drain("R8 window empty after group 7");

        // R11: classes 7, 5 and 6 dropped
        push(7, 80, 3'b000, 0, 0, 0);
        push(5, 82, 3'b000, 0, 0, 0);
        push(6, 83, 3'b000, 0, 0, 0);
        push(0, 81, 3'b000, 0, 0, 0);
        expect_b("R11 unkept classes dropped", 81, NOP, NOP, NOP, NOP);
        drain("R11 nothing else emitted");

        // R9 R10: fill window, back-pressure, stall stability
        for (int n = 0; n < 8; n++) push(0, 90 + n, 3'b000, 0, 0, 0);
        @(negedge clk);
        check(!in_ready, "R9 in_ready low when full", 64'(in_ready), 64'd0);
        check(bundle_key() == {8'd94, 8'd93, 8'd92, 8'd91, 8'd90}, "R10 bundle before stall",
              64'(bundle_key()), 64'h5e5d5c5b5a);
        repeat (3) @(negedge clk);
        check(out_valid && bundle_key() == {8'd94, 8'd93, 8'd92, 8'd91, 8'd90},
              "R10 bundle held under stall", 64'(bundle_key()), 64'h5e5d5c5b5a);
        expect_b("R10 first bundle after stall", 90, 91, 92, 93, 94);
        expect_b("R8 remainder of full window", 95, 96, 97, NOP, NOP);
        drain("R9 window empty after full group");
        @(negedge clk);
        check(in_ready, "R9 in_ready back high", 64'(in_ready), 64'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule